// File: doc/BRIEF.md
# PSRAM Refresh Configuration Register

This block holds the refresh configuration word of a pseudo-static RAM and turns it into the control levels the rest of the memory uses. It decides whether self refresh runs, whether that refresh covers the whole array or none of it, and whether page mode is enabled for asynchronous reads. It also runs the deep power-down sequence. Clearing the power-down bit stops all refresh and marks the stored data as lost. Setting the bit again starts a fixed initialization interval, and the device reports not ready for that whole interval.

Two write paths reach the register. The first is a direct strobe that carries the value on an 18-bit address-style bus, where bit 17 picks between this register and the neighbouring bus configuration register. The second is a software-access sequence, which selects this register with a key word of zero. Only the direct path can change the power-down bit. Reserved bits are always stored as zero, and a write that tries to set one is reported with a single-cycle error pulse.

Top module: `psram_refresh_cfg`

## Requirements
- R1: After reset, cfg_o is 17'h00010, ready_o is 1, dpd_o is 0, refresh_en_o is 1, full_cover_o is 1, page_en_o is 0, data_lost_o is 0 and rsv_err_o is 0.
- R2: A direct write (direct_we_i with direct_addr_i[17]=0) stores direct_addr_i[16:0], reserved bits masked, in cfg_o at the next clock edge. With direct_addr_i[17]=1 the write goes to the other register and cfg_o does not change.
- R3: A software write (sw_we_i) stores sw_data_i only when sw_key_i is 16'h0000. Any other key leaves cfg_o unchanged.
- R4: Field cfg_o[2:0] is the coverage code. The code 3'b100 means no coverage, so full_cover_o=0 and refresh_en_o=0. Every other code gives full_cover_o=1, and refresh_en_o then equals ready_o.
- R5: A direct write with bit 4 equal to 0, made while the device is running, enters deep power-down from the next edge: dpd_o=1, ready_o=0, refresh_en_o=0.
- R6: A software write never changes cfg_o[4] or the power-down state. The stored bit 4 keeps its previous value.
- R7: A direct write with bit 4 equal to 1, made during deep power-down, starts initialization. ready_o stays 0 for exactly CLK_MHZ*INIT_US cycles and then returns to 1.
- R8: page_en_o follows cfg_o[7].
- R9: Bits 16:8, 6, 5 and 3 of cfg_o are always 0. rsv_err_o is high for one cycle after an accepted write that had any of those bits at 1.
- R10: Writes from either path during initialization are ignored.
- R11: data_lost_o is set on entry to deep power-down and held until dl_clr_i. If a set and a clear fall in the same cycle, the set wins.
- R12: If a direct write and a selected software write arrive in the same cycle, the direct write is the one stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| direct_we_i | input | 1 | Direct write strobe |
| direct_addr_i | input | 18 | Direct write bus: bit 17 selects the register, bits 16:0 carry the value |
| sw_we_i | input | 1 | Write from the software-access sequence |
| sw_key_i | input | 16 | Key word of the sequence; 16'h0000 selects this register |
| sw_data_i | input | 17 | Value written by the software sequence |
| dl_clr_i | input | 1 | Clears the data-lost flag |
| cfg_o | output | 17 | Stored register value |
| refresh_en_o | output | 1 | Self refresh active |
| full_cover_o | output | 1 | Coverage code selects the full array |
| page_en_o | output | 1 | Page mode enabled for asynchronous reads |
| ready_o | output | 1 | Device usable: not in power-down or initialization |
| dpd_o | output | 1 | Deep power-down active |
| data_lost_o | output | 1 | Sticky flag: array contents lost |
| rsv_err_o | output | 1 | One-cycle pulse after a write that set a reserved bit |

## Verification
The bench measures the length of the initialization lockout cycle by cycle. A counter that is off by one, or that reloads when a write arrives in the middle of the interval, shows up as a wrong count. It sends a software write that clears bit 4, both while running and while powered down. A design that lets that path touch power-down would drop refresh or wake the device. A write made during initialization must not change cfg_o, a same-cycle collision between the two paths must store the direct value, and a clear that arrives together with power-down entry must not win over the new data-lost event. Writes aimed at the bus configuration register, or carrying a nonzero key, must leave the stored value unchanged.

// File: rtl/psram_rcfg_pkg.sv
package psram_rcfg_pkg;
  localparam int unsigned CFG_W    = 17;
  localparam int unsigned KEY_W    = 16;
  localparam int unsigned DPD_BIT  = 4;
  localparam int unsigned PAGE_BIT = 7;
  localparam logic [CFG_W-1:0] CFG_RESET = 17'h00010;
  localparam logic [CFG_W-1:0] RSV_MASK  = 17'h1FF68;
  localparam logic [2:0]       PAR_NONE  = 3'b100;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_DPD  = 2'd1,
    ST_INIT = 2'd2
  } dpd_state_e;
endpackage

// File: rtl/rcfg_wr_path.sv
module rcfg_wr_path
  import psram_rcfg_pkg::*;
(
  input  logic             direct_we_i,
  input  logic [CFG_W:0]   direct_addr_i,
  input  logic             sw_we_i,
  input  logic [KEY_W-1:0] sw_key_i,
  input  logic [CFG_W-1:0] sw_data_i,
  input  logic [CFG_W-1:0] cfg_q_i,
  input  logic             accept_i,
  output logic             wr_en_o,
  output logic             wr_direct_o,
  output logic [CFG_W-1:0] wr_val_o,
  output logic             rsv_hit_o
);
  logic direct_sel, sw_sel;
  logic [CFG_W-1:0] raw;

  assign direct_sel = direct_we_i && !direct_addr_i[CFG_W];
  assign sw_sel     = sw_we_i && (sw_key_i == '0);

  always_comb begin
    wr_direct_o = direct_sel;
    wr_en_o     = accept_i && (direct_sel || sw_sel);
    raw         = direct_sel ? direct_addr_i[CFG_W-1:0] : sw_data_i;
    wr_val_o    = raw & ~RSV_MASK;
    // software path cannot move the power-down bit
    if (!direct_sel) wr_val_o[DPD_BIT] = cfg_q_i[DPD_BIT];
    rsv_hit_o   = wr_en_o && ((raw & RSV_MASK) != '0);
  end
endmodule

// File: rtl/rcfg_dpd_seq.sv
module rcfg_dpd_seq
  import psram_rcfg_pkg::*;
#(
  parameter int unsigned INIT_CYCLES = 18750,
  localparam int unsigned CNT_W = $clog2(INIT_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  logic wr_direct_i,
  input  logic wr_dpd_bit_i,
  input  logic dl_clr_i,
  output logic accept_o,
  output logic ready_o,
  output logic dpd_o,
  output logic data_lost_o
);
  dpd_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic enter, leave;

  assign enter = wr_en_i && (state_q == ST_RUN) && !wr_dpd_bit_i;
  assign leave = wr_en_i && wr_direct_i && (state_q == ST_DPD) && wr_dpd_bit_i;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_RUN:  if (enter) state_d = ST_DPD;
      ST_DPD:  if (leave) begin
                 state_d = ST_INIT;
                 cnt_d   = CNT_W'(INIT_CYCLES - 1);
               end
      ST_INIT: if (cnt_q == '0) state_d = ST_RUN;
               else cnt_d = cnt_q - 1'b1;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_RUN;
      cnt_q       <= '0;
      data_lost_o <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (enter)         data_lost_o <= 1'b1;
      else if (dl_clr_i) data_lost_o <= 1'b0;
    end
  end

  assign accept_o = (state_q != ST_INIT);
  assign ready_o  = (state_q == ST_RUN);
  assign dpd_o    = (state_q == ST_DPD);
endmodule

// File: rtl/rcfg_decode.sv
module rcfg_decode
  import psram_rcfg_pkg::*;
(
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             ready_i,
  output logic             refresh_en_o,
  output logic             full_cover_o,
  output logic             page_en_o
);
  assign full_cover_o = (cfg_i[2:0] != PAR_NONE);
  assign refresh_en_o = ready_i && full_cover_o;
  assign page_en_o    = cfg_i[PAGE_BIT];
endmodule

// File: rtl/psram_refresh_cfg.sv
module psram_refresh_cfg
  import psram_rcfg_pkg::*;
#(
  parameter int unsigned CLK_MHZ = 125,
  parameter int unsigned INIT_US = 150
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             direct_we_i,
  input  logic [17:0]      direct_addr_i,
  input  logic             sw_we_i,
  input  logic [15:0]      sw_key_i,
  input  logic [16:0]      sw_data_i,
  input  logic             dl_clr_i,
  output logic [16:0]      cfg_o,
  output logic             refresh_en_o,
  output logic             full_cover_o,
  output logic             page_en_o,
  output logic             ready_o,
  output logic             dpd_o,
  output logic             data_lost_o,
  output logic             rsv_err_o
);
  localparam int unsigned INIT_CYCLES = CLK_MHZ * INIT_US;

  logic             wr_en, wr_direct, rsv_hit, accept;
  logic [CFG_W-1:0] wr_val, cfg_q;

  rcfg_wr_path u_wr (
    .direct_we_i  (direct_we_i),
    .direct_addr_i(direct_addr_i),
    .sw_we_i      (sw_we_i),
    .sw_key_i     (sw_key_i),
    .sw_data_i    (sw_data_i),
    .cfg_q_i      (cfg_q),
    .accept_i     (accept),
    .wr_en_o      (wr_en),
    .wr_direct_o  (wr_direct),
    .wr_val_o     (wr_val),
    .rsv_hit_o    (rsv_hit)
  );

  rcfg_dpd_seq #(.INIT_CYCLES(INIT_CYCLES)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en),
    .wr_direct_i (wr_direct),
    .wr_dpd_bit_i(wr_val[DPD_BIT]),
    .dl_clr_i    (dl_clr_i),
    .accept_o    (accept),
    .ready_o     (ready_o),
    .dpd_o       (dpd_o),
    .data_lost_o (data_lost_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q     <= CFG_RESET;
      rsv_err_o <= 1'b0;
    end else begin
      if (wr_en) cfg_q <= wr_val;
      rsv_err_o <= rsv_hit;
    end
  end

  rcfg_decode u_dec (
    .cfg_i       (cfg_q),
    .ready_i     (ready_o),
    .refresh_en_o(refresh_en_o),
    .full_cover_o(full_cover_o),
    .page_en_o   (page_en_o)
  );

  assign cfg_o = cfg_q;
endmodule

// File: rtl/rcfg_checker.sv
module rcfg_checker
  import psram_rcfg_pkg::*;
#(
  parameter int unsigned CLK_MHZ = 125,
  parameter int unsigned INIT_US = 150
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        direct_we_i,
  input logic [17:0] direct_addr_i,
  input logic        sw_we_i,
  input logic [16:0] cfg_o,
  input logic        refresh_en_o,
  input logic        ready_o,
  input logic        dpd_o,
  input logic        data_lost_o
);
  localparam int unsigned INIT_CYCLES = CLK_MHZ * INIT_US;
  logic [31:0] low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) low_cnt <= '0;
    else if (!ready_o && !dpd_o) low_cnt <= low_cnt + 1;
    else low_cnt <= '0;
  end

  AST_INIT_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> (low_cnt == INIT_CYCLES)); // R7
  AST_DPD_NO_REFRESH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dpd_o |-> !refresh_en_o && !ready_o); // R5
  AST_RSV_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_o & RSV_MASK) == '0); // R9
  AST_SW_KEEPS_DPD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_we_i && !direct_we_i) |=> ($stable(cfg_o[DPD_BIT]) && $stable(dpd_o))); // R6
  AST_LOST_ON_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dpd_o) |-> data_lost_o); // R11
  AST_INIT_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !dpd_o) |=> $stable(cfg_o)); // R10
  AST_BCR_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (direct_we_i && direct_addr_i[17] && !sw_we_i) |=> $stable(cfg_o)); // R2
endmodule

bind psram_refresh_cfg rcfg_checker #(.CLK_MHZ(CLK_MHZ), .INIT_US(INIT_US)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .direct_we_i  (direct_we_i),
  .direct_addr_i(direct_addr_i),
  .sw_we_i      (sw_we_i),
  .cfg_o        (cfg_o),
  .refresh_en_o (refresh_en_o),
  .ready_o      (ready_o),
  .dpd_o        (dpd_o),
  .data_lost_o  (data_lost_o)
);

// File: tb/tb_psram_refresh_cfg.sv
module tb_psram_refresh_cfg;
  localparam int unsigned CLK_MHZ = 125;
  localparam int unsigned INIT_US = 150;
  localparam int unsigned INIT_CYCLES = CLK_MHZ * INIT_US;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        direct_we_i = 1'b0, sw_we_i = 1'b0, dl_clr_i = 1'b0;
  logic [17:0] direct_addr_i = '0;
  logic [15:0] sw_key_i = '0;
  logic [16:0] sw_data_i = '0;
  logic [16:0] cfg_o;
  logic refresh_en_o, full_cover_o, page_en_o, ready_o, dpd_o, data_lost_o, rsv_err_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  psram_refresh_cfg #(.CLK_MHZ(CLK_MHZ), .INIT_US(INIT_US)) dut (.*);

  // vector: [40:39] path 1=direct 2=sw, [38] alt (addr bit17 / nonzero key),
  // [37:21] data, [20:4] expected cfg, [3] expected err, [2:0] unused
  localparam int NV = 8;
  localparam logic [40:0] VEC [NV] = '{
    {2'd1, 1'b0, 17'h00090, 17'h00090, 1'b0, 3'd0}, // R8 page on
    {2'd1, 1'b1, 17'h00010, 17'h00090, 1'b0, 3'd0}, // R2 other register
    {2'd2, 1'b0, 17'h00014, 17'h00014, 1'b0, 3'd0}, // R3 R4 none coverage
    {2'd2, 1'b1, 17'h00090, 17'h00014, 1'b0, 3'd0}, // R3 wrong key
    {2'd1, 1'b0, 17'h1FFFF, 17'h00097, 1'b1, 3'd0}, // R9 masked
    {2'd2, 1'b0, 17'h00000, 17'h00010, 1'b0, 3'd0}, // R6 bit4 kept
    {2'd1, 1'b0, 17'h00013, 17'h00013, 1'b0, 3'd0}, // R4 other code full
    {2'd1, 1'b0, 17'h00118, 17'h00010, 1'b1, 3'd0}  // R9 reserved dropped
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // drive for one clock edge, release and leave at the next negedge
  task automatic direct_wr(input logic [17:0] a);
    @(negedge clk_i); direct_we_i = 1'b1; direct_addr_i = a;
    @(negedge clk_i); direct_we_i = 1'b0;
  endtask

  task automatic sw_wr(input logic [15:0] k, input logic [16:0] d);
    @(negedge clk_i); sw_we_i = 1'b1; sw_key_i = k; sw_data_i = d;
    @(negedge clk_i); sw_we_i = 1'b0;
  endtask

  task automatic measure_init(input bool_write_mid);
    int low = 0;
    for (int i = 0; i < INIT_CYCLES + 100 && !ready_o; i++) begin
      low++;
      if (bool_write_mid && low == 5) begin direct_we_i = 1'b1; direct_addr_i = 18'h00080; end
      else direct_we_i = 1'b0;
      if (bool_write_mid && low == 6) chk("R10", "cfg during init", cfg_o, 17'h00010);
      @(negedge clk_i);
    end
    direct_we_i = 1'b0;
    chk("R7", "init low cycles", low, INIT_CYCLES);
    chk("R7", "ready after init", ready_o, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", "cfg", cfg_o, 17'h00010);
    chk("R1", "ready", ready_o, 1);
    chk("R1", "dpd", dpd_o, 0);
    chk("R1", "refresh", refresh_en_o, 1);
    chk("R1", "cover", full_cover_o, 1);
    chk("R1", "page", page_en_o, 0);
    chk("R1", "lost", data_lost_o, 0);
    chk("R1", "err", rsv_err_o, 0);

    for (int v = 0; v < NV; v++) begin
      logic [16:0] e;
      e = VEC[v][20:4];
      if (VEC[v][40:39] == 2'd1) direct_wr({VEC[v][38], VEC[v][37:21]});
      else sw_wr(VEC[v][38] ? 16'h0003 : 16'h0000, VEC[v][37:21]);
      chk("R2/R3/R9", $sformatf("vec %0d cfg", v), cfg_o, e);
      chk("R9", $sformatf("vec %0d err", v), rsv_err_o, VEC[v][3]);
      chk("R4", $sformatf("vec %0d cover", v), full_cover_o, e[2:0] != 3'b100);
      chk("R4", $sformatf("vec %0d refresh", v), refresh_en_o, e[2:0] != 3'b100);
      chk("R8", $sformatf("vec %0d page", v), page_en_o, e[7]);
      @(negedge clk_i);
      chk("R9", $sformatf("vec %0d err one cycle", v), rsv_err_o, 0);
    end

    // R12: collision, direct wins
    @(negedge clk_i);
    direct_we_i = 1'b1; direct_addr_i = 18'h00090;
    sw_we_i = 1'b1; sw_key_i = '0; sw_data_i = 17'h00014;
    @(negedge clk_i); direct_we_i = 1'b0; sw_we_i = 1'b0;
    chk("R12", "collision cfg", cfg_o, 17'h00090);

    // R6: software clear of bit4 while running
    sw_wr(16'h0000, 17'h00000);
    chk("R6", "sw no dpd", dpd_o, 0);
    chk("R6", "sw bit4", cfg_o[4], 1);

    // R5 R11: enter power-down
    direct_wr(18'h00000);
    chk("R5", "dpd", dpd_o, 1);
    chk("R5", "ready", ready_o, 0);
    chk("R5", "refresh", refresh_en_o, 0);
    chk("R11", "lost set", data_lost_o, 1);

    // R6: software set of bit4 while powered down
    sw_wr(16'h0000, 17'h00010);
    chk("R6", "still dpd", dpd_o, 1);
    chk("R6", "bit4 stays 0", cfg_o[4], 0);

    // R11: clear
    @(negedge clk_i); dl_clr_i = 1'b1;
    @(negedge clk_i); dl_clr_i = 1'b0;
    chk("R11", "lost cleared", data_lost_o, 0);

    // R7 R10: exit with write in the middle
    direct_wr(18'h00010);
    chk("R7", "ready low at start", ready_o, 0);
    chk("R7", "not dpd", dpd_o, 0);
    measure_init(1'b1);
    chk("R10", "cfg after init", cfg_o, 17'h00010);

    // R11: set beats clear
    @(negedge clk_i);
    direct_we_i = 1'b1; direct_addr_i = 18'h00000; dl_clr_i = 1'b1;
    @(negedge clk_i); direct_we_i = 1'b0; dl_clr_i = 1'b0;
    chk("R11", "set wins", data_lost_o, 1);
    chk("R5", "dpd again", dpd_o, 1);

    direct_wr(18'h00010);
    measure_init(1'b0);
    chk("R11", "lost held", data_lost_o, 1);

    summary();
  end
endmodule